// File: doc/BRIEF.md
# Split-width transmit DMA engine

This block is a single-channel engine that moves a buffer from memory into the holding register of a serial transmitter. Software gives it a start address, a byte length and a word-mode flag, then pulses a start input. The engine cuts the buffer into a leading run of whole 32-bit words and a trailing run of zero to three single bytes. It reads each unit through a valid/ready memory port and writes it, at the matching width, to one fixed device address.

Every access waits for the transmitter's ready request, and one request allows exactly one read and one write. When word mode is off, the whole buffer goes out as bytes. A segment with no bytes in it is skipped. At the end the engine raises a one-cycle done pulse together with the number of bytes it moved. A start whose word run would begin on an unaligned address is refused with a one-cycle error pulse.

Top module: `tx_split_dma`

## Requirements
- R1: With word mode on (`word_en`=1), the first `len & ~3` bytes move as 32-bit accesses (`mem_rd_word`=1, `dev_wr_size`=1). The remaining `len & 3` bytes then move as byte accesses (`mem_rd_word`=0, `dev_wr_size`=0), in that order.
- R2: With word mode off (`word_en`=0), all `len` bytes move as byte accesses, and no word access occurs.
- R3: The read address starts at `start_addr` and steps by 4 after each word access and by 1 after each byte access, so the byte run begins right after the word run. Every device write goes to `dev_wr_addr` = HOLD_ADDR (default 0x1C).
- R4: A word write carries all 32 bits read. A byte write carries the read's bits [7:0] in bits [7:0], with bits [31:8] zero.
- R5: A read is raised only after `dev_req` has been sampled high while the engine waits. Each accepted read is followed by exactly one one-cycle write. `mem_rd_valid` holds with a stable address until `mem_rd_ready`.
- R6: A start with `start_len`=0 performs no access and gives `done`=1 with `done_count`=0 in the cycle after start.
- R7: After the last write, `done` is high for one cycle, `busy` falls in that same cycle, and `done_count` equals the transfer's byte length.
- R8: A start pulse while `busy` is high has no effect on the running transfer, and it does not begin another one.
- R9: With `word_en`=1, `start_len`>=4 and `start_addr[1:0]`!=0, `align_err` pulses for one cycle after start, and no access and no busy period follow. With `start_len`<4 the address may be unaligned.
- R10: After reset, `busy`, `done`, `align_err`, `mem_rd_valid` and `dev_wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled when idle |
| word_en | input | 1 | 1 = split into word run plus byte tail |
| start_addr | input | AW | Source address of the buffer |
| start_len | input | LW | Buffer length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | LW | Bytes moved by the finished transfer |
| align_err | output | 1 | One-cycle pulse: start refused, unaligned word run |
| dev_req | input | 1 | Transmitter can take one more access |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_addr | output | AW | Read byte address |
| mem_rd_word | output | 1 | 1 = 32-bit read, 0 = byte read |
| mem_rd_ready | input | 1 | Memory accepts read, data valid this cycle |
| mem_rd_data | input | 32 | Read data |
| dev_wr_en | output | 1 | Device write strobe |
| dev_wr_addr | output | DAW | Holding register address |
| dev_wr_size | output | 1 | 1 = 32-bit write, 0 = byte write |
| dev_wr_data | output | 32 | Device write data |

## Verification
The bench sweeps every length from 0 to 13 against all four address offsets, in both word and byte mode. This catches a split that rounds the wrong way, which would change the count of word and byte accesses, and a tail that restarts at the start address instead of after the word run. The memory model fills the upper bits of byte reads with junk, so a byte write that is not zero-extended shows up as a data mismatch. Unaligned starts must be refused with no traffic, while short unaligned buffers must run as bytes. A second start during a busy transfer must leave the access log and byte count untouched. A held-low ready request must produce no reads at all.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } tsd_state_e;
endpackage

// File: rtl/tsd_split.sv
// Cuts a byte length into a word run and a byte tail, and flags a bad base.
module tsd_split #(
  parameter int LW = 12
) (
  input  logic [LW-1:0] len,
  input  logic          word_en,
  input  logic [1:0]    addr_lo,
  output logic [LW-1:0] word_len,
  output logic [LW-1:0] tail_len,
  output logic          len_zero,
  output logic          misalign
);
  localparam logic [LW-1:0] ZERO = '0;

  assign word_len = word_en ? {len[LW-1:2], 2'b00} : ZERO;
  assign tail_len = word_en ? {{(LW-2){1'b0}}, len[1:0]} : len;
  assign len_zero = (len == ZERO);
  assign misalign = (word_len != ZERO) && (addr_lo != 2'b00);
endmodule

// File: rtl/tsd_ctrl.sv
// Access sequencer: wait for request, read, write, then next or finish.
module tsd_ctrl
  import tsd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic len_zero,
  input  logic misalign,
  input  logic dev_req,
  input  logic rd_ready,
  input  logic seg_empty,
  input  logic tail_pend,
  output logic clr,
  output logic load,
  output logic step,
  output logic to_tail,
  output logic rd_valid,
  output logic wr_en,
  output logic busy,
  output logic done,
  output logic err
);
  tsd_state_e state_q;

  assign clr     = (state_q == ST_IDLE) && start;
  assign load    = clr && !len_zero && !misalign;
  assign step    = (state_q == ST_READ) && rd_ready;
  assign to_tail = (state_q == ST_WRITE) && seg_empty && tail_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      rd_valid <= 1'b0;
      wr_en    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (len_zero) begin
              done <= 1'b1;
            end else if (misalign) begin
              err <= 1'b1;
            end else begin
              state_q <= ST_WAIT;
              busy    <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (dev_req) begin
            state_q  <= ST_READ;
            rd_valid <= 1'b1;
          end
        end
        ST_READ: begin
          if (rd_ready) begin
            state_q  <= ST_WRITE;
            rd_valid <= 1'b0;
            wr_en    <= 1'b1;
          end
        end
        ST_WRITE: begin
          wr_en <= 1'b0;
          if (seg_empty && !tail_pend) begin
            state_q <= ST_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsd_dp.sv
// Address, segment and byte counters plus the write data register.
module tsd_dp #(
  parameter int AW     = 16,
  parameter int LW     = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic              step,
  input  logic              to_tail,
  input  logic [AW-1:0]     start_addr,
  input  logic [LW-1:0]     word_len,
  input  logic [LW-1:0]     tail_len,
  input  logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     addr,
  output logic              seg_word,
  output logic              seg_empty,
  output logic              tail_pend,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_size,
  output logic [LW-1:0]     total
);
  localparam int              BYTES_W = DATA_W / 8;
  localparam logic [AW-1:0]   A_WORD  = AW'(BYTES_W);
  localparam logic [AW-1:0]   A_BYTE  = AW'(1);
  localparam logic [LW-1:0]   L_WORD  = LW'(BYTES_W);
  localparam logic [LW-1:0]   L_BYTE  = LW'(1);

  logic [LW-1:0] seg_left_q;
  logic [LW-1:0] tail_left_q;
  logic [LW-1:0] l_step;

  assign l_step    = seg_word ? L_WORD : L_BYTE;
  assign seg_empty = (seg_left_q == '0);
  assign tail_pend = (tail_left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr        <= '0;
      seg_word    <= 1'b0;
      seg_left_q  <= '0;
      tail_left_q <= '0;
      wr_data     <= '0;
      wr_size     <= 1'b0;
      total       <= '0;
    end else begin
      if (clr) begin
        total <= '0;
      end
      if (load) begin
        addr <= start_addr;
        if (word_len != '0) begin
          seg_word    <= 1'b1;
          seg_left_q  <= word_len;
          tail_left_q <= tail_len;
        end else begin
          seg_word    <= 1'b0;
          seg_left_q  <= tail_len;
          tail_left_q <= '0;
        end
      end else if (step) begin
        addr       <= addr + (seg_word ? A_WORD : A_BYTE);
        seg_left_q <= seg_left_q - l_step;
        total      <= total + l_step;
        wr_size    <= seg_word;
        wr_data    <= seg_word ? rd_data : {{(DATA_W-8){1'b0}}, rd_data[7:0]};
      end else if (to_tail) begin
        seg_word    <= 1'b0;
        seg_left_q  <= tail_left_q;
        tail_left_q <= '0;
      end
    end
  end
endmodule

// File: rtl/tx_split_dma.sv
module tx_split_dma #(
  parameter int              AW        = 16,
  parameter int              LW        = 12,
  parameter int              DAW       = 8,
  parameter logic [DAW-1:0]  HOLD_ADDR = 8'h1C
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            word_en,
  input  logic [AW-1:0]   start_addr,
  input  logic [LW-1:0]   start_len,
  output logic            busy,
  output logic            done,
  output logic [LW-1:0]   done_count,
  output logic            align_err,
  input  logic            dev_req,
  output logic            mem_rd_valid,
  output logic [AW-1:0]   mem_rd_addr,
  output logic            mem_rd_word,
  input  logic            mem_rd_ready,
  input  logic [31:0]     mem_rd_data,
  output logic            dev_wr_en,
  output logic [DAW-1:0]  dev_wr_addr,
  output logic            dev_wr_size,
  output logic [31:0]     dev_wr_data
);
  logic [LW-1:0] word_len, tail_len;
  logic          len_zero, misalign;
  logic          clr, load, step, to_tail;
  logic          seg_empty, tail_pend;

  tsd_split #(.LW(LW)) u_split (
    .len      (start_len),
    .word_en  (word_en),
    .addr_lo  (start_addr[1:0]),
    .word_len (word_len),
    .tail_len (tail_len),
    .len_zero (len_zero),
    .misalign (misalign)
  );

  tsd_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .len_zero  (len_zero),
    .misalign  (misalign),
    .dev_req   (dev_req),
    .rd_ready  (mem_rd_ready),
    .seg_empty (seg_empty),
    .tail_pend (tail_pend),
    .clr       (clr),
    .load      (load),
    .step      (step),
    .to_tail   (to_tail),
    .rd_valid  (mem_rd_valid),
    .wr_en     (dev_wr_en),
    .busy      (busy),
    .done      (done),
    .err       (align_err)
  );

  tsd_dp #(.AW(AW), .LW(LW), .DATA_W(32)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .load       (load),
    .step       (step),
    .to_tail    (to_tail),
    .start_addr (start_addr),
    .word_len   (word_len),
    .tail_len   (tail_len),
    .rd_data    (mem_rd_data),
    .addr       (mem_rd_addr),
    .seg_word   (mem_rd_word),
    .seg_empty  (seg_empty),
    .tail_pend  (tail_pend),
    .wr_data    (dev_wr_data),
    .wr_size    (dev_wr_size),
    .total      (done_count)
  );

  assign dev_wr_addr = HOLD_ADDR;
endmodule

// File: rtl/tsd_chk.sv
module tsd_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          align_err,
  input logic          dev_req,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr,
  input logic          mem_rd_word,
  input logic          dev_wr_en
);
  AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_valid) |-> $past(dev_req)); // R5
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    dev_wr_en |-> $past(mem_rd_valid && mem_rd_ready)); // R5
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    dev_wr_en |=> !dev_wr_en); // R5
  AST_RD_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R5
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && mem_rd_word) |-> (mem_rd_addr[1:0] == 2'b00)); // R9
  AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (rst)
    align_err |-> (!busy && !mem_rd_valid && !dev_wr_en)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7
endmodule

bind tx_split_dma tsd_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .done         (done),
  .align_err    (align_err),
  .dev_req      (dev_req),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_word  (mem_rd_word),
  .dev_wr_en    (dev_wr_en)
);

// File: tb/tx_split_dma_tb.sv
module tx_split_dma_tb;
  localparam int AW = 16;
  localparam int LW = 12;
  localparam int DAW = 8;
  localparam logic [DAW-1:0] HOLD = 8'h1C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic word_en = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] start_len = '0;
  logic busy, done, align_err;
  logic [LW-1:0] done_count;
  logic dev_req = 1'b0;
  logic mem_rd_valid, mem_rd_word;
  logic [AW-1:0] mem_rd_addr;
  logic mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_data;
  logic dev_wr_en, dev_wr_size;
  logic [DAW-1:0] dev_wr_addr;
  logic [31:0] dev_wr_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit hold_req = 1'b0;

  logic [AW-1:0] rd_a_log [0:31];
  logic          rd_w_log [0:31];
  logic [31:0]   wr_d_log [0:31];
  logic          wr_s_log [0:31];
  logic [DAW-1:0] wr_a_log [0:31];
  int rd_n = 0;
  int wr_n = 0;

  always #10 clk = ~clk;

  tx_split_dma #(.AW(AW), .LW(LW), .DAW(DAW), .HOLD_ADDR(HOLD)) u_dut (
    .clk(clk), .rst(rst), .start(start), .word_en(word_en),
    .start_addr(start_addr), .start_len(start_len),
    .busy(busy), .done(done), .done_count(done_count), .align_err(align_err),
    .dev_req(dev_req), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_word(mem_rd_word), .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
    .dev_wr_en(dev_wr_en), .dev_wr_addr(dev_wr_addr), .dev_wr_size(dev_wr_size),
    .dev_wr_data(dev_wr_data)
  );

  function automatic logic [7:0] fb(input logic [AW-1:0] a);
    return a[7:0] * 8'd13 + 8'd5;
  endfunction

  function automatic logic [31:0] fw(input logic [AW-1:0] a);
    return {fb(a + 16'd3), fb(a + 16'd2), fb(a + 16'd1), fb(a)};
  endfunction

  assign mem_rd_data = mem_rd_word ? fw(mem_rd_addr) : {24'hA5C3E1, fb(mem_rd_addr)};

  always @(posedge clk) begin
    if (mem_rd_valid && mem_rd_ready) begin
      if (rd_n < 32) begin
        rd_a_log[rd_n] <= mem_rd_addr;
        rd_w_log[rd_n] <= mem_rd_word;
      end
      rd_n <= rd_n + 1;
    end
    if (dev_wr_en) begin
      if (wr_n < 32) begin
        wr_d_log[wr_n] <= dev_wr_data;
        wr_s_log[wr_n] <= dev_wr_size;
        wr_a_log[wr_n] <= dev_wr_addr;
      end
      wr_n <= wr_n + 1;
    end
  end

  // stimulus for request and ready, changed away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      dev_req      = !hold_req && ((cyc % 5) != 0);
      mem_rd_ready = ((cyc % 3) != 1);
    end
  end

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [LW-1:0] n);
    @(negedge clk);
    rd_n = 0;
    wr_n = 0;
    word_en = we;
    start_addr = a;
    start_len = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 400 && !done; t++) @(negedge clk);
  endtask

  task automatic verify(input bit we, input logic [AW-1:0] a, input int n);
    int nw;
    int bad_sz;
    int bad_a;
    int bad_d;
    logic [AW-1:0] ea;
    logic [31:0] ed;
    nw = we ? (n / 4) : 0;
    bad_sz = 0; bad_a = 0; bad_d = 0;
    chk(rd_n == n - 3 * nw && wr_n == n - 3 * nw,
        $sformatf("%s access count we=%0d len=%0d: rd=%0d wr=%0d exp %0d",
                  we ? "R1" : "R2", we, n, rd_n, wr_n, n - 3 * nw));
    for (int k = 0; k < n - 3 * nw && k < 32; k++) begin
      if (k < nw) begin
        ea = a + AW'(4 * k);
        ed = fw(ea);
      end else begin
        ea = a + AW'(4 * nw + (k - nw));
        ed = {24'h0, fb(ea)};
      end
      if (rd_w_log[k] != (k < nw) || wr_s_log[k] != (k < nw)) bad_sz++;
      if (rd_a_log[k] != ea || wr_a_log[k] != HOLD) bad_a++;
      if (wr_d_log[k] != ed) bad_d++;
    end
    chk(bad_sz == 0, $sformatf("%s access widths we=%0d len=%0d: %0d wrong exp 0",
                               we ? "R1" : "R2", we, n, bad_sz));
    chk(bad_a == 0, $sformatf("R3 addresses a=%h len=%0d: %0d wrong exp 0", a, n, bad_a));
    chk(bad_d == 0, $sformatf("R4 write data a=%h len=%0d: %0d wrong exp 0", a, n, bad_d));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !align_err && !mem_rd_valid && !dev_wr_en,
        $sformatf("R10 reset outputs busy=%b done=%b err=%b rv=%b we=%b exp all 0",
                  busy, done, align_err, mem_rd_valid, dev_wr_en));
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // sweep: mode x offset x length
    for (int we = 0; we < 2; we++) begin
      for (int off = 0; off < 4; off++) begin
        for (int n = 0; n < 14; n++) begin
          logic [AW-1:0] a;
          a = AW'(16'h0100 + 16'h40 * n + off);
          issue(we[0], a, LW'(n));
          if (n == 0) begin
            chk(done && done_count == 0 && !busy,
                $sformatf("R6 zero length done=%b cnt=%0d busy=%b exp 1 0 0", done, done_count, busy));
            repeat (5) @(negedge clk);
            chk(rd_n == 0 && wr_n == 0, $sformatf("R6 zero length accesses %0d exp 0", rd_n + wr_n));
          end else if (we == 1 && off != 0 && n >= 4) begin
            chk(align_err && !busy, $sformatf("R9 unaligned start err=%b busy=%b exp 1 0", align_err, busy));
            repeat (8) @(negedge clk);
            chk(rd_n == 0 && wr_n == 0 && !busy && !align_err,
                $sformatf("R9 refused start accesses=%0d busy=%b exp 0 0", rd_n + wr_n, busy));
          end else begin
            chk(!align_err && busy, $sformatf("R9 accepted start err=%b busy=%b exp 0 1", align_err, busy));
            wait_done();
            chk(done && !busy && done_count == LW'(n),
                $sformatf("R7 completion done=%b busy=%b cnt=%0d exp 1 0 %0d", done, busy, done_count, n));
            @(negedge clk);
            chk(!done, $sformatf("R7 done pulse width done=%b exp 0", done));
            verify(we[0], a, n);
          end
        end
      end
    end

    // R8: start while busy is ignored
    issue(1'b1, 16'h0200, 12'd9);
    repeat (3) @(negedge clk);
    word_en = 1'b0;
    start_addr = 16'h0300;
    start_len = 12'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(done && done_count == 12'd9, $sformatf("R8 count after busy start cnt=%0d exp 9", done_count));
    verify(1'b1, 16'h0200, 9);
    repeat (20) @(negedge clk);
    chk(!busy && rd_n == 3, $sformatf("R8 no second transfer busy=%b reads=%0d exp 0 3", busy, rd_n));

    // R5: no read while request held low
    hold_req = 1'b1;
    issue(1'b1, 16'h0400, 12'd6);
    repeat (30) @(negedge clk);
    chk(rd_n == 0 && !mem_rd_valid && busy,
        $sformatf("R5 reads without request=%0d valid=%b busy=%b exp 0 0 1", rd_n, mem_rd_valid, busy));
    hold_req = 1'b0;
    wait_done();
    chk(done && done_count == 12'd6, $sformatf("R5 finish after request cnt=%0d exp 6", done_count));
    verify(1'b1, 16'h0400, 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule